// File: doc/BRIEF.md
# SEC-DED Checker and Corrector for a 68-bit Word

This block checks a 68-bit data word that travels with an 8-bit check byte. It can correct any single flipped bit and detect any two flipped bits. It recomputes the seven Hamming check bits and the overall parity bit from the received data, compares them with the received check byte, and forms a syndrome. From that syndrome it repairs a single bad data bit. It also raises one of three flags: a correctable single error, an uncorrectable error, or an error confined to the check byte. The check-bit equations live in a single generator module. A writer can use the same module to produce the check byte it stores.

The path from input to output is purely combinational. The checker sits in a valid/ready stream and has no storage. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle. When the consumer holds `out_ready` low, the producer must keep the beat on the input pins. The corrected data and the flags then stay unchanged for as long as the beat is held. A beat is transferred in a cycle where both `in_valid` and `out_ready` are high.

Top module: `ecc68_checker`

## Requirements
- R1: When the check byte matches the data, the syndrome is zero, every flag is low, and `out_data` equals `in_data`. A matching check byte is defined as follows. Bit i (i = 0..6) is the even parity of the data bits whose codeword position has bit i set. Bit 7 is the even parity of all 68 data bits together with check bits 0..6.
- R2: Codeword positions work as follows. Check bit i (i = 0..6) sits at position 2^i. Check bit 7 sits at position 76 and belongs to none of the groups for bits 0..6. Data bit j takes the j-th position that is not a power of two, counting upward from 3. So bit 0 is at 3, bit 1 at 5, bit 4 at 9, bit 11 at 17, bit 26 at 33, bit 57 at 65 and bit 67 at 75.
- R3: `out_syndrome[6:0]` is the recomputed check bits 0..6 XOR the received check bits 0..6. `out_syndrome[7]` is the parity of all 76 received bits, so it is 1 when an odd number of bits are flipped.
- R4: If exactly one data bit is flipped, that bit is restored on `out_data` and `out_corr` = 1. In that case `out_uncorr` = 0 and `out_chk_only` = 0.
- R5: If exactly one of check bits 0..6 is flipped, the syndrome bits 6:0 form a power of two. The block then sets `out_corr` = 1 and `out_chk_only` = 1, and passes the data through unchanged.
- R6: If check bit 7 alone is flipped, `out_syndrome` = 8'h80. The block then sets `out_corr` = 1 and `out_chk_only` = 1, and passes the data through unchanged.
- R7: If any two bits are flipped, `out_uncorr` = 1, `out_corr` = 0 and `out_chk_only` = 0, and the data is passed through unchanged.
- R8: An odd parity error whose syndrome bits 6:0 fall in 76..127 is reported with `out_uncorr` = 1 and `out_corr` = 0, and the data is passed through unchanged.
- R9: `out_corr` and `out_uncorr` are never high together, and `out_data` differs from `in_data` in at most one bit.
- R10: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle. While a beat is held under back-pressure, every output stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Producer has a beat on in_data/in_chk |
| in_ready | output | 1 | Checker can accept the beat (mirrors out_ready) |
| in_data | input | 68 | Received data word |
| in_chk | input | 8 | Received check byte, bit 7 = overall parity |
| out_valid | output | 1 | Checked beat is present (mirrors in_valid) |
| out_ready | input | 1 | Consumer accepts the checked beat |
| out_data | output | 68 | Corrected data word |
| out_syndrome | output | 8 | {parity error, 7-bit position syndrome} |
| out_corr | output | 1 | Single error found and handled |
| out_uncorr | output | 1 | Error that cannot be corrected |
| out_chk_only | output | 1 | Single error was in the check byte; data untouched |

## Verification
Correction of a data bit and back-pressure can happen in the same cycle: a beat carrying a single flipped data bit may be held while `out_ready` is low. The bench provokes this by presenting such a beat, stalling it across several clock edges, and then releasing it. It judges the result by requiring that the repaired word and the correctable flag stay constant while the beat is held, and that `in_ready` follows the stall. Every single flip and every pair of flips over all 76 positions is also checked for the right data and flags.

// File: rtl/ecc68_pkg.sv
package ecc68_pkg;
  parameter int DATA_W = 68;
  parameter int SYN_W  = 7;
  localparam int CHK_W    = SYN_W + 1;
  localparam int LAST_POS = DATA_W + SYN_W;

  // Codeword position of data bit j: j-th non power of two from 3 upward.
  function automatic int dpos(input int j);
    int n;
    int r;
    n = 0;
    r = 0;
    for (int p = 3; p < 4096; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j && r == 0) r = p;
        n++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/ecc68_gen.sv
// Check byte generator, usable on the write side and by the checker.
module ecc68_gen #(
  parameter int DATA_W = ecc68_pkg::DATA_W,
  parameter int SYN_W  = ecc68_pkg::SYN_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [SYN_W:0]    chk
);
  logic [SYN_W-1:0][DATA_W-1:0] sel;

  for (genvar i = 0; i < SYN_W; i++) begin : g_bit
    for (genvar j = 0; j < DATA_W; j++) begin : g_dat
      localparam int P = ecc68_pkg::dpos(j);
      assign sel[i][j] = P[i] ? data[j] : 1'b0;
    end
    assign chk[i] = ^sel[i];
  end

  // Overall parity over data and the seven group bits.
  assign chk[SYN_W] = (^data) ^ (^chk[SYN_W-1:0]);
endmodule

// File: rtl/ecc68_locate.sv
// Turns a position syndrome into a one-hot data bit mask.
module ecc68_locate #(
  parameter int DATA_W = ecc68_pkg::DATA_W,
  parameter int SYN_W  = ecc68_pkg::SYN_W
) (
  input  logic [SYN_W-1:0]  syn,
  output logic [DATA_W-1:0] hit
);
  for (genvar j = 0; j < DATA_W; j++) begin : g_cmp
    localparam int P = ecc68_pkg::dpos(j);
    assign hit[j] = (syn == P[SYN_W-1:0]);
  end

  always_comb begin
    // R2
    hit_onehot_chk: assert ($onehot0(hit));
  end
endmodule

// File: rtl/ecc68_classify.sv
// Decides correct / flag from syndrome and parity error.
module ecc68_classify #(
  parameter int SYN_W    = ecc68_pkg::SYN_W,
  parameter int LAST_POS = ecc68_pkg::LAST_POS
) (
  input  logic [SYN_W-1:0] syn,
  input  logic             par_err,
  output logic             fix_en,
  output logic             corr,
  output logic             uncorr,
  output logic             chk_only
);
  localparam logic [SYN_W-1:0] MAXP = SYN_W'(LAST_POS);

  logic syn_nz, pow2, in_range;

  always_comb begin
    syn_nz   = |syn;
    pow2     = syn_nz && ((syn & (syn - 1'b1)) == '0);
    in_range = syn <= MAXP;
    chk_only = par_err && (!syn_nz || pow2);
    fix_en   = par_err && syn_nz && !pow2 && in_range;
    corr     = chk_only || fix_en;
    uncorr   = (!par_err && syn_nz) || (par_err && !in_range);
  end

  always_comb begin
    // R7
    even_err_uncorr_chk: assert (par_err || !syn_nz || (uncorr && !corr));
    // R8
    range_uncorr_chk: assert (!(par_err && syn > MAXP) || (uncorr && !fix_en));
  end
endmodule

// File: rtl/ecc68_checker.sv
module ecc68_checker #(
  parameter int DATA_W = ecc68_pkg::DATA_W,
  parameter int SYN_W  = ecc68_pkg::SYN_W,
  localparam int CHK_W = SYN_W + 1
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHK_W-1:0]  in_chk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CHK_W-1:0]  out_syndrome,
  output logic              out_corr,
  output logic              out_uncorr,
  output logic              out_chk_only
);
  logic [CHK_W-1:0]  recomp;
  logic [SYN_W-1:0]  syn;
  logic              par_err;
  logic [DATA_W-1:0] hit;
  logic              fix_en;

  ecc68_gen #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_gen (
    .data (in_data),
    .chk  (recomp)
  );

  assign syn     = recomp[SYN_W-1:0] ^ in_chk[SYN_W-1:0];
  // Whole-codeword parity = regenerated overall bit vs received bits.
  assign par_err = recomp[SYN_W] ^ in_chk[SYN_W] ^ (^syn);

  ecc68_locate #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_loc (
    .syn (syn),
    .hit (hit)
  );

  ecc68_classify #(.SYN_W(SYN_W), .LAST_POS(DATA_W + SYN_W)) u_cls (
    .syn      (syn),
    .par_err  (par_err),
    .fix_en   (fix_en),
    .corr     (out_corr),
    .uncorr   (out_uncorr),
    .chk_only (out_chk_only)
  );

  assign out_data     = in_data ^ (hit & {DATA_W{fix_en}});
  assign out_syndrome = {par_err, syn};
  assign out_valid    = in_valid;
  assign in_ready     = out_ready;

  always_comb begin
    // R9
    flag_excl_chk: assert (!(out_corr && out_uncorr));
    // R9
    one_bit_fix_chk: assert ($countones(out_data ^ in_data) <= 1);
    // R5
    chk_only_keep_chk: assert (!out_chk_only || (out_corr && out_data == in_data));
    // R1
    clean_pass_chk: assert (out_syndrome != '0 ||
                            (!out_corr && !out_uncorr && out_data == in_data));
  end
endmodule

// File: tb/test_ecc68_checker.sv
module test_ecc68_checker;
  logic        clk = 1'b0;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [67:0] in_data, out_data;
  logic [7:0]  in_chk, out_syndrome;
  logic        out_corr, out_uncorr, out_chk_only;
  int          n_run = 0;
  int          n_fail = 0;
  int          cycles = 0;

  always #4 clk = ~clk;

  ecc68_checker i_ecc68_checker (
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_chk(in_chk),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_syndrome(out_syndrome), .out_corr(out_corr), .out_uncorr(out_uncorr),
    .out_chk_only(out_chk_only)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int flog2(input int p);
    int r = 0;
    while ((1 << (r + 1)) <= p) r++;
    return r;
  endfunction

  // Data index at position p (p not a power of two, 3..75): R2
  function automatic int pos2idx(input int p);
    return p - (flog2(p) + 1) - 1;
  endfunction

  function automatic logic [7:0] ref_gen(input logic [67:0] d);
    logic [7:0] c = '0;
    int p = 3;
    for (int j = 0; j < 68; j++) begin
      while ((p & (p - 1)) == 0) p++;
      for (int i = 0; i < 7; i++) if (p[i]) c[i] ^= d[j];
      p++;
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic flip(inout logic [67:0] d, inout logic [7:0] c, input int p);
    if (p == 76) c[7] ^= 1'b1;
    else if ((p & (p - 1)) == 0) c[flog2(p)] ^= 1'b1;
    else d[pos2idx(p)] ^= 1'b1;
  endtask

  // Apply a word with up to three flipped positions (0 = unused) and judge it.
  task automatic run_case(input logic [67:0] d0, input int pa, input int pb, input int pc,
                          input string req);
    logic [67:0] d = d0;
    logic [7:0]  c = ref_gen(d0);
    logic [6:0]  s = '0;
    int          n = 0;
    logic        e_corr, e_unc, e_co;
    logic [67:0] e_dat;
    int          plist[3];
    plist = '{pa, pb, pc};
    foreach (plist[k]) if (plist[k] != 0) begin
      flip(d, c, plist[k]);
      if (plist[k] != 76) s ^= 7'(plist[k]);
      n++;
    end
    e_corr = 1'b0; e_unc = 1'b0; e_co = 1'b0; e_dat = d;
    if (n == 1) begin
      e_corr = 1'b1;
      e_co   = (pa == 76) || ((pa & (pa - 1)) == 0);
      e_dat  = d0;
    end else if (n >= 2) begin
      e_unc = 1'b1;
    end
    in_data = d; in_chk = c;
    #2;
    chk({req, " syndrome"}, 128'(out_syndrome), 128'({n[0], s}));
    chk({req, " corr"},     128'(out_corr),     128'(e_corr));
    chk({req, " uncorr"},   128'(out_uncorr),   128'(e_unc));
    chk({req, " chk_only"}, 128'(out_chk_only), 128'(e_co));
    chk({req, " data"},     128'(out_data),     128'(e_dat));
  endtask

  localparam logic [67:0] PAT0 = 68'h0;
  localparam logic [67:0] PAT1 = 68'hF_FFFF_FFFF_FFFF_FFFF;
  localparam logic [67:0] PAT2 = 68'hA_5C3E_9017_6BD2_4F81;

  task automatic t_idle;
    in_valid = 1'b0; out_ready = 1'b0; in_data = '0; in_chk = '0;
    #2;
    chk("R10 idle out_valid", 128'(out_valid), 128'(0));
    chk("R10 idle in_ready",  128'(in_ready),  128'(0));
    chk("R1 idle flags", 128'({out_corr, out_uncorr, out_chk_only}), 128'(0));
  endtask

  task automatic t_clean;
    run_case(PAT0, 0, 0, 0, "R1 clean zero");
    run_case(PAT1, 0, 0, 0, "R1 clean ones");
    run_case(PAT2, 0, 0, 0, "R1 clean mixed");
    // R2 known map points: data bit alone gives its position as group bits
    in_data = 68'h1 << 4;  in_chk = 8'h0; #2;
    chk("R2 D4 at 9",  128'(out_syndrome), 128'(8'h89));
    in_data = 68'h1 << 57; in_chk = 8'h0; #2;
    chk("R2 D57 at 65", 128'(out_syndrome), 128'(8'hC1));
    in_data = 68'h1 << 67; in_chk = 8'h0; #2;
    chk("R3 D67 at 75", 128'(out_syndrome), 128'(8'hCB));
  endtask

  task automatic t_single;
    for (int p = 1; p <= 76; p++) begin
      if (p == 76) begin
        run_case(PAT2, p, 0, 0, "R6 flip C7");
      end else if ((p & (p - 1)) == 0) begin
        run_case(PAT1, p, 0, 0, "R5 flip check");
      end else begin
        run_case(PAT0, p, 0, 0, "R4 flip data z");
        run_case(PAT2, p, 0, 0, "R4 flip data m");
      end
    end
  endtask

  task automatic t_double;
    for (int p = 1; p <= 76; p++)
      for (int q = p + 1; q <= 76; q++)
        run_case(((p + q) % 2 == 0) ? PAT2 : PAT1, p, q, 0, "R7 double");
  endtask

  task automatic t_range;
    run_case(PAT2, 64, 12, 1, "R8 syn 77");
    run_case(PAT0, 64, 8, 4, "R8 syn 76");
    run_case(PAT1, 64, 32, 16, "R8 syn 112");
    run_case(PAT2, 64, 32, 31, "R9 syn 127");
  endtask

  task automatic t_stream;
    logic [67:0] d = PAT2;
    logic [7:0]  c = ref_gen(PAT2);
    flip(d, c, 40);
    in_data = d; in_chk = c; in_valid = 1'b1; out_ready = 1'b0;
    #2;
    chk("R10 valid follows", 128'(out_valid), 128'(1));
    chk("R10 ready follows stall", 128'(in_ready), 128'(0));
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      chk("R10 held data", 128'(out_data), 128'(PAT2));
      chk("R10 held corr", 128'(out_corr), 128'(1));
    end
    out_ready = 1'b1; #2;
    chk("R10 ready released", 128'(in_ready), 128'(1));
    chk("R4 fixed on release", 128'(out_data), 128'(PAT2));
    in_valid = 1'b0; #2;
    chk("R10 valid drops", 128'(out_valid), 128'(0));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<200000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    t_idle;
    t_clean;
    in_valid = 1'b1; out_ready = 1'b1;
    t_single;
    t_double;
    t_range;
    t_stream;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule